// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of parameterisable width and returns their full double-width signed product. It retires one multiplier bit per clock cycle using radix-2 Booth recoding. Each step looks at the lowest multiplier bit and the bit that was shifted out before it. Depending on that pair, the step adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator unchanged. The step then shifts the accumulator, the multiplier register and the extra low bit right by one position as a single arithmetic shift.

A caller drives both operands and raises `start_i` for one cycle while the block is idle. `busy_o` stays high for exactly `WIDTH` cycles. `done_o` then pulses for one cycle, and from that cycle `product_o` holds the result until the next accepted start. The accumulator carries one guard bit above the operand width, so subtracting the most negative multiplicand never wraps.

Top module: `booth_mul_seq`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `product_o` is 0.
- R2: A start sampled while idle sets `busy_o` on the next clock edge, and `busy_o` then stays high for exactly `WIDTH` cycles.
- R3: `done_o` is high for exactly one cycle, in the cycle where `busy_o` has just fallen.
- R4: When `done_o` is high, `product_o` equals the signed product of the captured multiplicand and multiplier, as a `2*WIDTH`-bit two's-complement value, for every combination of operand signs.
- R5: Operands equal to the most negative value, -2^(WIDTH-1), give a correct product as either operand or as both. Both at once gives +2^(2*WIDTH-2).
- R6: A start request while `busy_o` is high is ignored. The operation in flight keeps its operands and its cycle count.
- R7: While idle with `start_i` low, `product_o` does not change.
- R8: The accumulator never overflows when the multiplicand is added or subtracted, including subtraction of the most negative multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication; honoured only when idle |
| mcand_i | input | WIDTH | Signed multiplicand, captured on an accepted start |
| mplier_i | input | WIDTH | Signed multiplier, captured on an accepted start |
| busy_o | output | 1 | High while the recoding steps run |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2*WIDTH | Signed product, valid from `done_o` until the next accepted start |

## Verification
The assertions assume that `start_i` holds a defined value at every clock edge after reset. They also assume the operands are defined on the edge where a start is accepted. The accumulator overflow check is meaningful only once those operands have been captured. The bench drives all inputs on falling edges and keeps `start_i` low except in cycles where it requests an operation. It sweeps every operand pair of a 4-bit instance, including both most negative values. It injects stray start requests with different operands only while an operation is already running.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } booth_act_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_mul_pkg::*;
(
  input  logic       q0_i,
  input  logic       qm1_i,
  output booth_act_e act_o
);

  // 01: end of a run of ones -> add; 10: start of a run -> subtract
  always_comb begin
    unique case ({q0_i, qm1_i})
      2'b01:   act_o = ACT_ADD;
      2'b10:   act_o = ACT_SUB;
      default: act_o = ACT_NONE;
    endcase
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   acc_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  booth_act_e       act_i,
  output logic [WIDTH:0]   sum_o
);

  logic [WIDTH:0] mcand_ext;

  assign mcand_ext = {mcand_i[WIDTH-1], mcand_i};

  always_comb begin
    unique case (act_i)
      ACT_ADD: sum_o = acc_i + mcand_ext;
      ACT_SUB: sum_o = acc_i - mcand_ext;
      default: sum_o = acc_i;
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_step;

  assign load_o    = start_i && !busy_q;
  assign step_o    = busy_q;
  assign last_step = busy_q && (cnt_q == LAST);
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last_step;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (last_step) busy_q <= 1'b0;
        else           cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R3
  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $fell(busy_q)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= LAST)); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != LAST) |=> (busy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R6

endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);

  localparam int ACC_W = WIDTH + 1;

  logic [ACC_W-1:0] acc_q, sum;
  logic [WIDTH-1:0] mq_q, mcand_q;
  logic             qm1_q;
  logic             load, step;
  booth_act_e       act;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  booth_recode u_recode (
    .q0_i (mq_q[0]),
    .qm1_i(qm1_q),
    .act_o(act)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc_i  (acc_q),
    .mcand_i(mcand_q),
    .act_i  (act),
    .sum_o  (sum)
  );

  // arithmetic right shift across {acc, mq, qm1}
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mq_q    <= '0;
      qm1_q   <= 1'b0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= '0;
      mq_q    <= mplier_i;
      qm1_q   <= 1'b0;
      mcand_q <= mcand_i;
    end else if (step) begin
      acc_q   <= {sum[ACC_W-1], sum[ACC_W-1:1]};
      mq_q    <= {sum[0], mq_q[WIDTH-1:1]};
      qm1_q   <= mq_q[0];
    end
  end

  assign product_o = {acc_q[WIDTH-1:0], mq_q};

  // exact sum one bit wider than the accumulator, used to prove the guard bit suffices
  logic [ACC_W:0] wide_sum;
  always_comb begin
    unique case (act)
      ACT_ADD: wide_sum = {acc_q[ACC_W-1], acc_q} + {{2{mcand_q[WIDTH-1]}}, mcand_q};
      ACT_SUB: wide_sum = {acc_q[ACC_W-1], acc_q} - {{2{mcand_q[WIDTH-1]}}, mcand_q};
      default: wide_sum = {acc_q[ACC_W-1], acc_q};
    endcase
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> (wide_sum[ACC_W] == wide_sum[ACC_W-1])); // R8
  AST_MCAND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mcand_q)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o)); // R7
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2

endmodule

// File: tb/booth_mul_seq_test.sv
module booth_mul_seq_test;

  localparam int W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [W-1:0]     mcand = '0, mplier = '0;
  logic             busy, done;
  logic [2*W-1:0]   product;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  booth_mul_seq #(.WIDTH(W)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .mcand_i  (mcand),
    .mplier_i (mplier),
    .busy_o   (busy),
    .done_o   (done),
    .product_o(product)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] expect_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb, p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    p  = sa * sb;
    return p[2*W-1:0];
  endfunction

  // one operation; optional stray start with other operands at step 'stray_at'
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input int stray_at);
    int k;
    logic [2*W-1:0] exp_p;
    exp_p = expect_prod(a, b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mcand = ~a; mplier = ~b;
    check("R2 busy after start", longint'(busy), 1);
    k = 0;
    while (!done && k < 4 * W) begin
      if (stray_at == k) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    check("R2 busy length", k, W);
    check("R3 busy low at done", longint'(busy), 0);
    if ($signed(a) == -(2 ** (W - 1)) || $signed(b) == -(2 ** (W - 1)))
      check("R5 most negative product", longint'(product), longint'(exp_p));
    else if (stray_at >= 0)
      check("R6 product after stray start", longint'(product), longint'(exp_p));
    else
      check("R4 product", longint'(product), longint'(exp_p));
    @(negedge clk);
    check("R3 done single cycle", longint'(done), 0);
    check("R7 product held", longint'(product), longint'(exp_p));
  endtask

  initial begin
    #25;
    @(negedge clk);
    check("R1 busy reset", longint'(busy), 0);
    check("R1 done reset", longint'(done), 0);
    check("R1 product reset", longint'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 product after release", longint'(product), 0);

    for (int i = 0; i < (1 << W); i++)
      for (int j = 0; j < (1 << W); j++)
        run_op(W'(i), W'(j), -1);

    // R6: stray starts at several points of a running operation
    for (int s = 0; s < W - 1; s++) begin
      run_op(W'(5), W'(-3), s);
      run_op(W'(-8), W'(7), s);
    end

    // R7: long idle with changing operand inputs
    mcand = 4'h3; mplier = 4'h9;
    repeat (5) begin
      @(negedge clk);
      mcand = mcand + 4'h1;
      check("R7 idle hold", longint'(product), longint'(expect_prod(W'(-8), W'(7))));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule